// File: doc/BRIEF.md
# Serial Transceiver Mode Decoder and Loopback Router

This block sits between the control pins of a serial line transceiver and its data paths. A 4-bit control word is sampled on a system clock, synchronised, and split into two kinds of command by its top bit. With the top bit high, the three low bits are stored as the clock configuration:

- whether the internal oscillator or an external high-speed clock is used;
- the line rate;
- whether timing comes from the local reference or from the recovered receive clock.

With the top bit low, the three low bits select one device command. The commands are core reset, output tristate, input test chain, reference-clock tristate, frame-recovery disable, or one of three loopback schemes.

The loopback scheme steers the serial streams and their clocks. The multiplexer's transmit stream can be turned back into the demultiplexer. The received stream can be sent straight back out on the line outputs. Both can also be done at once. The stored clock configuration is kept while any test, reset or loopback command is applied, so changing diagnostics never disturbs the rate or timing source.

Top module: `trx_mode_ctrl`

## Requirements
- R1: After rst_n is released with the control word held at Fh, every command flag is low, the routing is pass-through, and the clock outputs read internal oscillator (pll_bypass_o=0), high rate (rate_hi_o=1) and master timing (master_o=1).
- R2: Code 0h asserts core_rst_o alone and leaves the routing pass-through.
- R3: Code 1h asserts tri_ttl_o alone. Code 3h asserts tri_ref_o alone. At most one command flag is high at any time.
- R4: Code 2h asserts nand_test_o alone. Code 4h asserts frm_dis_o alone.
- R5: Code 5h sends tx_data_i/tx_clk_i to dmx_data_o/dmx_clk_o and keeps the transmit stream on the line outputs. Code 6h sends rx_data_i/rx_clk_i to line_tx_data_o/line_tx_clk_o and keeps the receive stream on the demultiplexer. Code 7h does both.
- R6: Every code other than 5h, 6h and 7h gives pass-through routing: the line outputs carry tx_data_i/tx_clk_i and the demultiplexer outputs carry rx_data_i/rx_clk_i.
- R7: A code with bit 3 high stores its low bits as the clock configuration: bit 2 = 1 selects the internal oscillator (pll_bypass_o=0), bit 1 = 1 selects the high rate (rate_hi_o=1), bit 0 = 1 selects master timing (master_o=1). It also clears any pending command.
- R8: Codes 0h to 7h, including reset and all loopback codes, leave pll_bypass_o, rate_hi_o and master_o unchanged.
- R9: A control word takes effect only after it has been seen unchanged on two consecutive synchronised samples. A value present for a single clock cycle has no effect.
- R10: A new control word driven just after a rising edge reaches the outputs at the (SYNC_STAGES+2)-th rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for control sampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_i | input | CTL_W | Control word; bit 3 qualifies the low bits |
| rx_data_i | input | SER_W | Serial receive data from the line |
| rx_clk_i | input | 1 | Serial receive clock from the line |
| tx_data_i | input | SER_W | Serial transmit data from the multiplexer |
| tx_clk_i | input | 1 | Serial transmit clock from the multiplexer |
| line_tx_data_o | output | SER_W | Serial data to the line transmit outputs |
| line_tx_clk_o | output | 1 | Clock to the line transmit outputs |
| dmx_data_o | output | SER_W | Serial data into the demultiplexer |
| dmx_clk_o | output | 1 | Clock into the demultiplexer |
| core_rst_o | output | 1 | Reset for counters, dividers and phase detector |
| tri_ttl_o | output | 1 | Tristate request for the general outputs |
| tri_ref_o | output | 1 | Tristate request for the reference clock output |
| nand_test_o | output | 1 | Input test chain enable |
| frm_dis_o | output | 1 | Frame recovery disable |
| pll_bypass_o | output | 1 | External high-speed clock in use |
| rate_hi_o | output | 1 | High line rate selected |
| master_o | output | 1 | Master timing from the local reference |

## Verification
Every control result is due at the (SYNC_STAGES+2)-th rising edge after the word changes: SYNC_STAGES synchroniser flops, one flop of stability comparison, and the decode register. The bench drives each word just after a falling edge and samples one falling edge after that edge is due. One dedicated check samples a cycle early to prove the old value is still held there. The serial routing is combinational from the registered loopback state, so routing checks step the serial inputs and sample a nanosecond later. A single-cycle glitch is checked by waiting well past the due edge and confirming that neither routing nor flags moved.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;

   typedef enum logic [1:0] {
      LB_NORMAL = 2'd0,
      LB_EQUIP  = 2'd1,
      LB_FACIL  = 2'd2,
      LB_SPLIT  = 2'd3
   } lb_mode_e;

   typedef struct packed {
      logic vco_int;
      logic rate_hi;
      logic master;
   } clk_cfg_t;

   typedef struct packed {
      logic     core_rst;
      logic     tri_ttl;
      logic     nand_test;
      logic     tri_ref;
      logic     frm_dis;
      lb_mode_e lb;
   } cmd_t;

   localparam int CFG_W = 3;

endpackage

// File: rtl/trx_ctl_sync.sv
module trx_ctl_sync #(
   parameter int               CTL_W       = 4,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CTL_W-1:0] RST_VAL     = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl_i,
   output logic [CTL_W-1:0] ctl_s_o,
   output logic             stable_o
);

   logic [CTL_W-1:0] ctl_s;
   logic [CTL_W-1:0] ctl_p_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ctl_s = ctl_i;
      end else begin : g_sync
         logic [CTL_W-1:0] stg_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
               stg_q[0] <= ctl_i;
               for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign ctl_s = stg_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_p_q <= RST_VAL;
      else        ctl_p_q <= ctl_s;
   end

   assign ctl_s_o  = ctl_s;
   assign stable_o = (ctl_s == ctl_p_q);

endmodule

// File: rtl/trx_clk_cfg.sv
module trx_clk_cfg
   import trx_mode_pkg::*;
#(
   parameter int       CTL_W    = 4,
   parameter clk_cfg_t CFG_INIT = 3'b111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl_i,
   input  logic             stable_i,
   output clk_cfg_t         cfg_o
);

   localparam int QBIT = CTL_W - 1;

   clk_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cfg_q <= CFG_INIT;
      else if (stable_i && ctl_i[QBIT]) cfg_q <= clk_cfg_t'(ctl_i[CFG_W-1:0]);
   end

   assign cfg_o = cfg_q;

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_i[QBIT] |=> $stable(cfg_q)); // R8

   AST_CFG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !stable_i |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/trx_cmd_decode.sv
module trx_cmd_decode
   import trx_mode_pkg::*;
#(
   parameter int CTL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl_i,
   input  logic             stable_i,
   output cmd_t             cmd_o
);

   localparam int QBIT = CTL_W - 1;

   cmd_t cmd_n;
   cmd_t cmd_q;

   always_comb begin
      cmd_n    = '0;
      cmd_n.lb = LB_NORMAL;
      if (!ctl_i[QBIT]) begin
         case (ctl_i[2:0])
            3'd0: cmd_n.core_rst  = 1'b1;
            3'd1: cmd_n.tri_ttl   = 1'b1;
            3'd2: cmd_n.nand_test = 1'b1;
            3'd3: cmd_n.tri_ref   = 1'b1;
            3'd4: cmd_n.frm_dis   = 1'b1;
            3'd5: cmd_n.lb        = LB_EQUIP;
            3'd6: cmd_n.lb        = LB_FACIL;
            3'd7: cmd_n.lb        = LB_SPLIT;
            default: cmd_n.lb     = LB_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmd_q <= '0;
      else if (stable_i) cmd_q <= cmd_n;
   end

   assign cmd_o = cmd_q;

   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_q.core_rst, cmd_q.tri_ttl, cmd_q.nand_test,
                cmd_q.tri_ref, cmd_q.frm_dis, cmd_q.lb != LB_NORMAL})); // R3

   AST_RST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q.core_rst |-> cmd_q.lb == LB_NORMAL); // R2

   AST_CMD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !stable_i |=> $stable(cmd_q)); // R9

endmodule

// File: rtl/trx_loop_router.sv
module trx_loop_router
   import trx_mode_pkg::*;
#(
   parameter int SER_W = 1
) (
   input  lb_mode_e         lb_i,
   input  logic [SER_W-1:0] rx_data_i,
   input  logic             rx_clk_i,
   input  logic [SER_W-1:0] tx_data_i,
   input  logic             tx_clk_i,
   output logic [SER_W-1:0] line_data_o,
   output logic             line_clk_o,
   output logic [SER_W-1:0] dmx_data_o,
   output logic             dmx_clk_o
);

   logic rx_to_line;
   logic tx_to_dmx;

   assign rx_to_line = (lb_i == LB_FACIL) || (lb_i == LB_SPLIT);
   assign tx_to_dmx  = (lb_i == LB_EQUIP) || (lb_i == LB_SPLIT);

   generate
      for (genvar g = 0; g < SER_W; g++) begin : g_lane
         assign line_data_o[g] = rx_to_line ? rx_data_i[g] : tx_data_i[g];
         assign dmx_data_o[g]  = tx_to_dmx  ? tx_data_i[g] : rx_data_i[g];
      end
   endgenerate

   assign line_clk_o = rx_to_line ? rx_clk_i : tx_clk_i;
   assign dmx_clk_o  = tx_to_dmx  ? tx_clk_i : rx_clk_i;

endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
   import trx_mode_pkg::*;
#(
   parameter int       CTL_W       = 4,
   parameter int       SER_W       = 1,
   parameter int       SYNC_STAGES = 2,
   parameter clk_cfg_t CFG_INIT    = 3'b111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl_i,
   input  logic [SER_W-1:0] rx_data_i,
   input  logic             rx_clk_i,
   input  logic [SER_W-1:0] tx_data_i,
   input  logic             tx_clk_i,
   output logic [SER_W-1:0] line_tx_data_o,
   output logic             line_tx_clk_o,
   output logic [SER_W-1:0] dmx_data_o,
   output logic             dmx_clk_o,
   output logic             core_rst_o,
   output logic             tri_ttl_o,
   output logic             tri_ref_o,
   output logic             nand_test_o,
   output logic             frm_dis_o,
   output logic             pll_bypass_o,
   output logic             rate_hi_o,
   output logic             master_o
);

   localparam logic [CTL_W-1:0] SYNC_RST = {1'b1, CFG_INIT};

   generate
      if (CTL_W != CFG_W + 1) begin : g_bad_ctl
         $error("CTL_W must be one qualifier bit above the configuration field");
      end
      if (SER_W < 1) begin : g_bad_ser
         $error("SER_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_s;
   logic             stable;
   clk_cfg_t         cfg;
   cmd_t             cmd;

   trx_ctl_sync #(
      .CTL_W(CTL_W), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i),
      .ctl_s_o(ctl_s), .stable_o(stable)
   );

   trx_clk_cfg #(.CTL_W(CTL_W), .CFG_INIT(CFG_INIT)) u_cfg (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s), .stable_i(stable), .cfg_o(cfg)
   );

   trx_cmd_decode #(.CTL_W(CTL_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s), .stable_i(stable), .cmd_o(cmd)
   );

   trx_loop_router #(.SER_W(SER_W)) u_route (
      .lb_i(cmd.lb),
      .rx_data_i(rx_data_i), .rx_clk_i(rx_clk_i),
      .tx_data_i(tx_data_i), .tx_clk_i(tx_clk_i),
      .line_data_o(line_tx_data_o), .line_clk_o(line_tx_clk_o),
      .dmx_data_o(dmx_data_o), .dmx_clk_o(dmx_clk_o)
   );

   assign core_rst_o   = cmd.core_rst;
   assign tri_ttl_o    = cmd.tri_ttl;
   assign tri_ref_o    = cmd.tri_ref;
   assign nand_test_o  = cmd.nand_test;
   assign frm_dis_o    = cmd.frm_dis;
   assign pll_bypass_o = !cfg.vco_int;
   assign rate_hi_o    = cfg.rate_hi;
   assign master_o     = cfg.master;

   AST_LINE_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.lb == LB_FACIL || cmd.lb == LB_SPLIT) |-> line_tx_clk_o == rx_clk_i); // R5

   AST_DMX_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.lb == LB_EQUIP || cmd.lb == LB_SPLIT) |-> dmx_data_o == tx_data_i); // R5

   AST_RST_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o |-> (line_tx_data_o == tx_data_i && dmx_data_o == rx_data_i)); // R2

endmodule

// File: tb/tb_trx_mode_ctrl.sv
`timescale 1ns/1ps
module tb_trx_mode_ctrl;

   localparam int SER_W = 2;
   localparam int SYNC  = 2;
   localparam int LAT   = SYNC + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       ctl = 4'hF;
   logic [SER_W-1:0] rx_data = '0, tx_data = '0;
   logic             rx_clk = 1'b0, tx_clk = 1'b0;
   logic [SER_W-1:0] line_data, dmx_data;
   logic             line_clk, dmx_clk;
   logic core_rst, tri_ttl, tri_ref, nand_t, frm_dis, bypass, rate_hi, master;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   trx_mode_ctrl #(.SER_W(SER_W), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl),
      .rx_data_i(rx_data), .rx_clk_i(rx_clk),
      .tx_data_i(tx_data), .tx_clk_i(tx_clk),
      .line_tx_data_o(line_data), .line_tx_clk_o(line_clk),
      .dmx_data_o(dmx_data), .dmx_clk_o(dmx_clk),
      .core_rst_o(core_rst), .tri_ttl_o(tri_ttl), .tri_ref_o(tri_ref),
      .nand_test_o(nand_t), .frm_dis_o(frm_dis),
      .pll_bypass_o(bypass), .rate_hi_o(rate_hi), .master_o(master)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int flags();
      return {core_rst, tri_ttl, nand_t, tri_ref, frm_dis};
   endfunction

   function automatic int cfg_bits();
      return {bypass, rate_hi, master};
   endfunction

   task automatic apply(input logic [3:0] code);
      @(negedge clk);
      ctl = code;
      repeat (LAT) @(negedge clk);
   endtask

   // line_rx: line outputs expected from rx; dmx_tx: demux expected from tx
   task automatic route_chk(input bit line_rx, input bit dmx_tx, input string req);
      logic [SER_W-1:0] el, ed;
      logic ecl, ecd;
      for (int p = 0; p < 2; p++) begin
         rx_data = (p == 0) ? 2'b10 : 2'b01;
         tx_data = ~rx_data;
         rx_clk  = (p == 0);
         tx_clk  = (p != 0);
         #1;
         el  = line_rx ? rx_data : tx_data;
         ecl = line_rx ? rx_clk  : tx_clk;
         ed  = dmx_tx  ? tx_data : rx_data;
         ecd = dmx_tx  ? tx_clk  : rx_clk;
         chk(line_data == el && line_clk == ecl, {req, " line"},
             {line_clk, line_data}, {ecl, el});
         chk(dmx_data == ed && dmx_clk == ecd, {req, " dmx"},
             {dmx_clk, dmx_data}, {ecd, ed});
      end
   endtask

   task automatic t_reset();
      chk(flags() == 0, "R1 flags", flags(), 0);
      chk(cfg_bits() == 3'b011, "R1 cfg", cfg_bits(), 3'b011);
      route_chk(0, 0, "R1 route");
   endtask

   task automatic t_commands();
      apply(4'h0);
      chk(flags() == 5'b10000, "R2 reset flag", flags(), 5'b10000);
      route_chk(0, 0, "R2 route");
      apply(4'h1);
      chk(flags() == 5'b01000, "R3 tri_ttl", flags(), 5'b01000);
      route_chk(0, 0, "R6 code1");
      apply(4'h3);
      chk(flags() == 5'b00010, "R3 tri_ref", flags(), 5'b00010);
      apply(4'h2);
      chk(flags() == 5'b00100, "R4 nand", flags(), 5'b00100);
      apply(4'h4);
      chk(flags() == 5'b00001, "R4 frm_dis", flags(), 5'b00001);
      route_chk(0, 0, "R6 code4");
   endtask

   task automatic t_loops();
      apply(4'h5);
      chk(flags() == 0, "R5 equip flags", flags(), 0);
      route_chk(0, 1, "R5 equip");
      apply(4'h6);
      route_chk(1, 0, "R5 facility");
      apply(4'h7);
      route_chk(1, 1, "R5 split");
      apply(4'hC);
      route_chk(0, 0, "R6 code C");
      chk(flags() == 0, "R7 clears cmd", flags(), 0);
   endtask

   task automatic t_cfg();
      for (int c = 8; c < 16; c++) begin
         apply(4'(c));
         chk(cfg_bits() == {~c[2], c[1], c[0]}, "R7 cfg decode",
             cfg_bits(), {~c[2], c[1], c[0]});
      end
      apply(4'hA);
      for (int c = 0; c < 8; c++) begin
         apply(4'(c));
         chk(cfg_bits() == 3'b110, "R8 cfg held", cfg_bits(), 3'b110);
      end
   endtask

   task automatic t_glitch();
      apply(4'hF);
      @(negedge clk); ctl = 4'h6;
      @(negedge clk); ctl = 4'hF;
      repeat (LAT + 4) @(negedge clk);
      route_chk(0, 0, "R9 glitch route");
      chk(cfg_bits() == 3'b011, "R9 glitch cfg", cfg_bits(), 3'b011);
      @(negedge clk); ctl = 4'h8;
      @(negedge clk); ctl = 4'hF;
      repeat (LAT + 4) @(negedge clk);
      chk(cfg_bits() == 3'b011, "R9 cfg glitch", cfg_bits(), 3'b011);
   endtask

   task automatic t_latency();
      @(negedge clk); ctl = 4'h2;
      repeat (LAT - 1) @(negedge clk);
      chk(nand_t == 1'b0, "R10 early", nand_t, 0);
      @(negedge clk);
      chk(nand_t == 1'b1, "R10 due", nand_t, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_commands();
      t_loops();
      t_cfg();
      t_glitch();
      t_latency();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule